// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with Result Register Pair

This block performs 32-bit integer multiplication and division, signed and unsigned. It writes each result into its own pair of result registers, HI and LO, and never into a general register file. A requester issues one operation at a time with a start strobe and an operation code. It reads either result register through a read port that holds its ready signal low while an operation is in flight. HI and LO can also be loaded directly with move-to operations.

A multiply places the high word of the 64-bit product in HI and the low word in LO. A divide places the remainder in HI and the quotient in LO. The divider is iterative and retires one quotient bit per cycle. The multiplier is a single-cycle array fed from registered operands. A divide by zero finishes at once with a defined result and a one-cycle flag. A move-to issued while the unit is busy is held and applied when the running operation finishes. The reset input is asynchronous and active low, and the unit leaves reset on a clock edge.

Top module: `muldiv_hilo`

## Requirements
- R1: Operation code 1 (unsigned multiply) writes the high 32 bits of the unsigned 64-bit product opa*opb to HI and the low 32 bits to LO.
- R2: Operation code 0 (signed multiply) does the same with both operands taken as two's complement, so for example (-3)*5 gives HI=0xFFFFFFFF and LO=0xFFFFFFF1.
- R3: Operation code 3 (unsigned divide) with a nonzero divisor writes the quotient opa/opb to LO and the remainder to HI.
- R4: Operation code 2 (signed divide) rounds the quotient toward zero, and the remainder takes the sign of the dividend. For 0x80000000 divided by 0xFFFFFFFF the result is LO=0x80000000 and HI=0.
- R5: A multiply accepted on a clock edge raises busy for exactly one cycle, and HI and LO hold the product after the following edge.
- R6: A divide with a nonzero divisor keeps busy high for exactly 32 cycles after the accepting edge, and HI and LO change only on the edge where busy falls.
- R7: A divide (code 2 or 3) with opb=0 does not raise busy. On the accepting edge it writes LO=0xFFFFFFFF and HI=opa, and div_zero goes high for exactly the next cycle.
- R8: When idle, code 4 loads opa into HI and code 5 loads opa into LO on the next edge. The other register is left unchanged.
- R9: A code 4 or code 5 issued while busy is held and applied on the edge where the running operation completes. It replaces the computed result for that one register, and the latest such write wins.
- R10: rd_data shows HI when rd_sel=1 and LO when rd_sel=0. rd_ready equals rd_req while idle and is low whenever busy is high.
- R11: A multiply or divide issued while busy is ignored, and codes 6 and 7 never change HI or LO.
- R12: After reset HI and LO read as zero and busy and div_zero are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| start | input | 1 | Issue strobe for the operation in op |
| op | input | 3 | Operation code (0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div, 4 load HI, 5 load LO) |
| opa | input | 32 | First operand; dividend; value for a move-to |
| opb | input | 32 | Second operand; divisor |
| rd_req | input | 1 | Read request on the result read port |
| rd_sel | input | 1 | Read select: 1 for HI, 0 for LO |
| rd_ready | output | 1 | Read data valid; low while busy |
| rd_data | output | 32 | Selected result register |
| busy | output | 1 | A multiply or divide is in flight |
| div_zero | output | 1 | One-cycle pulse after a divide by zero |

## Verification
The assertions assume that start, op and the operands are steady around each rising edge, and that a requester only counts on an issue it made while busy was low. The stimulus changes inputs only on falling edges. It issues most multiplies and divides from the idle state, but it also issues some on purpose while busy, to exercise the ignore and deferral rules. The bench model follows the same acceptance rule, so issues made while busy appear in the comparison as ignored or pending rather than as new operations.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_MULS = 3'd0,
    OP_MULU = 3'd1,
    OP_DIVS = 3'd2,
    OP_DIVU = 3'd3,
    OP_WRHI = 3'd4,
    OP_WRLO = 3'd5
  } mdu_op_e;

endpackage

// File: rtl/mdu_rst_sync.sv
module mdu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sh_q[STAGES-1];

endmodule

// File: rtl/mdu_mult.sv
module mdu_mult #(
  parameter int W = 32
) (
  input  logic           sg,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);

  localparam int PW = 2 * W;

  logic [PW-1:0] a_ext;
  logic [PW-1:0] b_ext;

  // Sign-extend to the full product width; the modulo-2^PW product is then
  // correct for both two's complement and unsigned operands.
  always_comb begin
    a_ext = {{W{sg & a[W-1]}}, a};
    b_ext = {{W{sg & b[W-1]}}, b};
    prod  = a_ext * b_ext;
  end

endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         sg,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);

  localparam int            CW   = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          act_q, act_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [W-1:0]  acc_q, acc_n;
  logic [W-1:0]  sh_q, sh_n;
  logic [W-1:0]  dvs_q, dvs_n;
  logic          nq_q, nq_n;
  logic          nr_q, nr_n;
  logic          reg_en;

  logic [W-1:0]  mag_a, mag_b;
  logic [W:0]    trial;
  logic          fit;
  logic [W-1:0]  acc_s, sh_s;

  // one restoring step per cycle on operand magnitudes
  always_comb begin
    mag_a = (sg && dvd[W-1]) ? (~dvd + 1'b1) : dvd;
    mag_b = (sg && dvs[W-1]) ? (~dvs + 1'b1) : dvs;
    trial = {acc_q, sh_q[W-1]} - {1'b0, dvs_q};
    fit   = ~trial[W];
    acc_s = fit ? trial[W-1:0] : {acc_q[W-2:0], sh_q[W-1]};
    sh_s  = {sh_q[W-2:0], fit};
  end

  always_comb begin
    act_n = act_q;
    cnt_n = cnt_q;
    acc_n = acc_q;
    sh_n  = sh_q;
    dvs_n = dvs_q;
    nq_n  = nq_q;
    nr_n  = nr_q;
    if (go && !act_q) begin
      act_n = 1'b1;
      cnt_n = '0;
      acc_n = '0;
      sh_n  = mag_a;
      dvs_n = mag_b;
      nq_n  = sg & (dvd[W-1] ^ dvs[W-1]);
      nr_n  = sg & dvd[W-1];
    end else if (act_q) begin
      acc_n = acc_s;
      sh_n  = sh_s;
      cnt_n = cnt_q + 1'b1;
      if (cnt_q == LAST) act_n = 1'b0;
    end
  end

  assign reg_en = go | act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      acc_q <= '0;
      sh_q  <= '0;
      dvs_q <= '0;
      nq_q  <= 1'b0;
      nr_q  <= 1'b0;
    end else if (reg_en) begin
      act_q <= act_n;
      cnt_q <= cnt_n;
      acc_q <= acc_n;
      sh_q  <= sh_n;
      dvs_q <= dvs_n;
      nq_q  <= nq_n;
      nr_q  <= nr_n;
    end
  end

  assign busy = act_q;
  assign done = act_q && (cnt_q == LAST);
  assign quo  = nq_q ? (~sh_s + 1'b1) : sh_s;
  assign rem  = nr_q ? (~acc_s + 1'b1) : acc_s;

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         rd_req,
  input  logic         rd_sel,
  output logic         rd_ready,
  output logic [W-1:0] rd_data,
  output logic         busy,
  output logic         div_zero
);

  localparam logic [W-1:0] ALL1 = '1;

  logic         rst_s;

  logic         is_mul, is_div, is_whi, is_wlo;
  logic         acc_mul, acc_div, acc_dz;

  logic         mul_q, msg_q;
  logic [W-1:0] ma_q, mb_q;
  logic [2*W-1:0] prod;

  logic         div_busy, div_done;
  logic [W-1:0] div_quo, div_rem;

  logic         done;
  logic [W-1:0] res_hi, res_lo;

  logic [W-1:0] hi_q, hi_n, lo_q, lo_n;
  logic         ph_v_q, ph_v_n, pl_v_q, pl_v_n;
  logic [W-1:0] ph_d_q, ph_d_n, pl_d_q, pl_d_n;
  logic         phv_e, plv_e;
  logic [W-1:0] phd_e, pld_e;
  logic         dz_q, dz_n;
  logic         hi_en, lo_en, pend_en;

  mdu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_sn(rst_s)
  );

  // issue decode
  always_comb begin
    is_mul  = start && ((op == OP_MULS) || (op == OP_MULU));
    is_div  = start && ((op == OP_DIVS) || (op == OP_DIVU));
    is_whi  = start && (op == OP_WRHI);
    is_wlo  = start && (op == OP_WRLO);
    acc_mul = is_mul && !busy;
    acc_div = is_div && !busy && (opb != '0);
    acc_dz  = is_div && !busy && (opb == '0);
  end

  mdu_mult #(.W(W)) u_mult (
    .sg  (msg_q),
    .a   (ma_q),
    .b   (mb_q),
    .prod(prod)
  );

  mdu_div #(.W(W)) u_div (
    .clk  (clk),
    .rst_n(rst_s),
    .go   (acc_div),
    .sg   (op == OP_DIVS),
    .dvd  (opa),
    .dvs  (opb),
    .busy (div_busy),
    .done (div_done),
    .quo  (div_quo),
    .rem  (div_rem)
  );

  assign busy = mul_q | div_busy;
  assign done = mul_q | div_done;

  always_comb begin
    if (mul_q) begin
      res_hi = prod[2*W-1:W];
      res_lo = prod[W-1:0];
    end else begin
      res_hi = div_rem;
      res_lo = div_quo;
    end
  end

  // deferred move-to: a write arriving this cycle overrides the held one
  always_comb begin
    phv_e = ph_v_q | (is_whi && busy);
    plv_e = pl_v_q | (is_wlo && busy);
    phd_e = (is_whi && busy) ? opa : ph_d_q;
    pld_e = (is_wlo && busy) ? opa : pl_d_q;
  end

  // result register next state
  always_comb begin
    hi_n   = hi_q;
    lo_n   = lo_q;
    ph_v_n = phv_e;
    pl_v_n = plv_e;
    ph_d_n = phd_e;
    pl_d_n = pld_e;
    dz_n   = 1'b0;
    if (done) begin
      hi_n   = phv_e ? phd_e : res_hi;
      lo_n   = plv_e ? pld_e : res_lo;
      ph_v_n = 1'b0;
      pl_v_n = 1'b0;
    end else if (!busy) begin
      if (is_whi) hi_n = opa;
      if (is_wlo) lo_n = opa;
      if (acc_dz) begin
        hi_n = opa;
        lo_n = ALL1;
        dz_n = 1'b1;
      end
    end
  end

  assign hi_en   = done | (!busy && (is_whi || acc_dz));
  assign lo_en   = done | (!busy && (is_wlo || acc_dz));
  assign pend_en = busy;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_en) hi_q <= hi_n;
      if (lo_en) lo_q <= lo_n;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ph_v_q <= 1'b0;
      pl_v_q <= 1'b0;
      ph_d_q <= '0;
      pl_d_q <= '0;
    end else if (pend_en) begin
      ph_v_q <= ph_v_n;
      pl_v_q <= pl_v_n;
      ph_d_q <= ph_d_n;
      pl_d_q <= pl_d_n;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      mul_q <= 1'b0;
      msg_q <= 1'b0;
      ma_q  <= '0;
      mb_q  <= '0;
      dz_q  <= 1'b0;
    end else begin
      mul_q <= acc_mul;
      dz_q  <= dz_n;
      if (acc_mul) begin
        msg_q <= (op == OP_MULS);
        ma_q  <= opa;
        mb_q  <= opb;
      end
    end
  end

  assign div_zero = dz_q;
  assign rd_ready = rd_req & ~busy;
  assign rd_data  = rd_sel ? hi_q : lo_q;

endmodule

// File: rtl/mdu_checker.sv
module mdu_checker
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_sn,
  input logic         start,
  input logic [2:0]   op,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         rd_req,
  input logic         rd_ready,
  input logic         busy,
  input logic         div_zero,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);

  localparam int CW = $clog2(W) + 1;

  logic          trk_q;
  logic [CW-1:0] len_q;
  logic          acc_div_nz;

  assign acc_div_nz = start && !busy && (opb != '0) &&
                      ((op == OP_DIVS) || (op == OP_DIVU));

  // measures the busy window of a divide with a nonzero divisor
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      trk_q <= 1'b0;
      len_q <= '0;
    end else if (acc_div_nz) begin
      trk_q <= 1'b1;
      len_q <= '0;
    end else if (trk_q && busy) begin
      len_q <= len_q + 1'b1;
    end else if (trk_q) begin
      trk_q <= 1'b0;
    end
  end

  p_div_len_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (trk_q && !busy) |-> (len_q == CW'(W)));

  p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && $past(busy)) |-> ($stable(hi_q) && $stable(lo_q)));

  p_mul_window_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (start && !busy && ((op == OP_MULS) || (op == OP_MULU))) |=> busy ##1 !busy);

  p_dz_pulse_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    div_zero |=> !div_zero);

  p_dz_value_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    div_zero |-> ((lo_q == '1) && (hi_q == $past(opa)) && !busy));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_req && busy) |-> !rd_ready);

  p_no_op_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    (start && (op > 3'd5) && !busy) |=> ($stable(hi_q) && $stable(lo_q)));

endmodule

bind muldiv_hilo mdu_checker #(.W(W)) u_mdu_checker (
  .clk     (clk),
  .rst_sn  (rst_s),
  .start   (start),
  .op      (op),
  .opa     (opa),
  .opb     (opb),
  .rd_req  (rd_req),
  .rd_ready(rd_ready),
  .busy    (busy),
  .div_zero(div_zero),
  .hi_q    (hi_q),
  .lo_q    (lo_q)
);

// File: tb/test_muldiv_hilo.sv
`timescale 1ns/1ps
module test_muldiv_hilo;

  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [2:0]    op;
  logic [W-1:0]  opa, opb;
  logic          rd_req, rd_sel;
  logic          rd_ready;
  logic [W-1:0]  rd_data;
  logic          busy, div_zero;

  always #2 clk = ~clk;

  muldiv_hilo #(.W(W)) i_muldiv_hilo (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (op),
    .opa     (opa),
    .opb     (opb),
    .rd_req  (rd_req),
    .rd_sel  (rd_sel),
    .rd_ready(rd_ready),
    .rd_data (rd_data),
    .busy    (busy),
    .div_zero(div_zero)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    chk_en = 0;
  string cur_req = "R12";

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_hi, m_lo, r_hi, r_lo, p_hi, p_lo;
  bit          p_hi_v, p_lo_v, m_dz, dzn;
  int          m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = 0; m_lo = 0; r_hi = 0; r_lo = 0; p_hi = 0; p_lo = 0;
      p_hi_v = 0; p_lo_v = 0; m_dz = 0; m_cnt = 0;
    end else begin
      dzn = 0;
      if (m_cnt > 0) begin
        if (start && op == 3'd4) begin p_hi_v = 1; p_hi = opa; end
        if (start && op == 3'd5) begin p_lo_v = 1; p_lo = opa; end
        m_cnt--;
        if (m_cnt == 0) begin
          m_hi = p_hi_v ? p_hi : r_hi;
          m_lo = p_lo_v ? p_lo : r_lo;
          p_hi_v = 0; p_lo_v = 0;
        end
      end else if (start) begin
        case (op)
          3'd0: begin
            longint ps;
            ps = longint'($signed(opa)) * longint'($signed(opb));
            r_hi = ps[63:32]; r_lo = ps[31:0]; m_cnt = 1;
          end
          3'd1: begin
            logic [63:0] pu;
            pu = {32'd0, opa} * {32'd0, opb};
            r_hi = pu[63:32]; r_lo = pu[31:0]; m_cnt = 1;
          end
          3'd2, 3'd3: begin
            if (opb == 0) begin
              m_hi = opa; m_lo = 32'hFFFF_FFFF; dzn = 1;
            end else if (op == 3'd2) begin
              longint q, r;
              q = longint'($signed(opa)) / longint'($signed(opb));
              r = longint'($signed(opa)) % longint'($signed(opb));
              r_lo = q[31:0]; r_hi = r[31:0]; m_cnt = 32;
            end else begin
              r_lo = opa / opb; r_hi = opa % opb; m_cnt = 32;
            end
          end
          3'd4: m_hi = opa;
          3'd5: m_lo = opa;
          default: ;
        endcase
      end
      m_dz = dzn;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    #1;
    if (chk_en) begin
      logic          e_busy, e_rdy;
      logic [31:0]   e_data;
      e_busy = (m_cnt > 0);
      e_rdy  = rd_req && !e_busy;
      e_data = rd_sel ? m_hi : m_lo;
      n_chk++;
      if (busy !== e_busy || div_zero !== m_dz || rd_ready !== e_rdy || rd_data !== e_data) begin
        n_fail++;
        $display("FAIL %s cycle compare: busy/dz/rdy/data actual %b %b %b %h expected %b %b %b %h",
                 cur_req, busy, div_zero, rd_ready, rd_data, e_busy, m_dz, e_rdy, e_data);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rnd_rd();
    rd_sel = 1'($urandom);
    rd_req = 1'($urandom);
  endtask

  task automatic issue_now(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    start = 1; op = o; opa = a; opb = b; rnd_rd();
    @(negedge clk);
    start = 0; opa = $urandom; opb = $urandom; op = 3'($urandom);
  endtask

  task automatic issue(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    issue_now(o, a, b);
  endtask

  task automatic wait_idle();
    while (m_cnt > 0) begin
      rnd_rd();
      @(negedge clk);
    end
  endtask

  task automatic read_both(input string req, input logic [31:0] eh, input logic [31:0] el);
    @(negedge clk);
    rd_req = 1; rd_sel = 1; #1;
    chk(req, "HI read", rd_data, eh);
    chk(req, "ready while idle", {31'd0, rd_ready}, 32'd1);
    @(negedge clk);
    rd_req = 1; rd_sel = 0; #1;
    chk(req, "LO read", rd_data, el);
  endtask

  task automatic do_op(input string req, input logic [2:0] o, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] eh, input logic [31:0] el);
    cur_req = req;
    issue(o, a, b);
    wait_idle();
    read_both(req, eh, el);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL R6 watchdog: actual still running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 0; start = 0; op = 0; opa = 0; opb = 0; rd_req = 0; rd_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk_en = 1;

    // R12 reset state
    cur_req = "R12";
    read_both("R12", 32'h0, 32'h0);
    chk("R12", "busy after reset", {31'd0, busy}, 32'd0);
    chk("R12", "div_zero after reset", {31'd0, div_zero}, 32'd0);

    // R8 direct loads
    do_op("R8", 3'd4, 32'h1111_2222, 32'h0, 32'h1111_2222, 32'h0);
    do_op("R8", 3'd5, 32'h3333_4444, 32'h0, 32'h1111_2222, 32'h3333_4444);

    // R1 unsigned multiply
    do_op("R1", 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h0000_0001);
    do_op("R1", 3'd1, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000, 32'h0000_0000);
    do_op("R1", 3'd1, 32'd123456, 32'd1000, 32'h0000_0000, 32'd123456000);

    // R2 signed multiply
    do_op("R2", 3'd0, 32'hFFFF_FFFD, 32'd5, 32'hFFFF_FFFF, 32'hFFFF_FFF1);
    do_op("R2", 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h1);
    do_op("R2", 3'd0, 32'h8000_0000, 32'h8000_0000, 32'h4000_0000, 32'h0);

    // R3 unsigned divide
    do_op("R3", 3'd3, 32'd100, 32'd7, 32'd2, 32'd14);
    do_op("R3", 3'd3, 32'hFFFF_FFFF, 32'h10, 32'hF, 32'h0FFF_FFFF);
    do_op("R3", 3'd3, 32'd5, 32'd9, 32'd5, 32'd0);

    // R4 signed divide
    do_op("R4", 3'd2, 32'hFFFF_FFF9, 32'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFD);
    do_op("R4", 3'd2, 32'd7, 32'hFFFF_FFFE, 32'd1, 32'hFFFF_FFFD);
    do_op("R4", 3'd2, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0, 32'h8000_0000);

    // R5 multiply timing
    cur_req = "R5";
    issue(3'd1, 32'd6, 32'd7);
    #1 chk("R5", "busy one cycle after accept", {31'd0, busy}, 32'd1);
    @(negedge clk); rd_req = 1; rd_sel = 0; #1;
    chk("R5", "busy dropped", {31'd0, busy}, 32'd0);
    chk("R5", "product in LO", rd_data, 32'd42);

    // R6 divide timing
    cur_req = "R6";
    begin
      int n_busy;
      n_busy = 0;
      issue(3'd3, 32'd1000, 32'd3);
      #1;
      while (busy) begin
        n_busy++;
        @(negedge clk); #1;
      end
      chk("R6", "divide busy cycles", n_busy, 32'd32);
    end
    read_both("R6", 32'd1, 32'd333);

    // R10 stall while busy
    cur_req = "R10";
    issue(3'd3, 32'd77, 32'd7);
    rd_req = 1; rd_sel = 1; #1;
    chk("R10", "ready low while busy", {31'd0, rd_ready}, 32'd0);
    wait_idle();
    read_both("R10", 32'd0, 32'd11);

    // R7 divide by zero
    cur_req = "R7";
    issue(3'd2, 32'hFFFF_FFF9, 32'd0);
    #1;
    chk("R7", "div_zero raised", {31'd0, div_zero}, 32'd1);
    chk("R7", "no busy", {31'd0, busy}, 32'd0);
    @(negedge clk); #1;
    chk("R7", "div_zero one cycle", {31'd0, div_zero}, 32'd0);
    read_both("R7", 32'hFFFF_FFF9, 32'hFFFF_FFFF);
    do_op("R7", 3'd3, 32'h1234_5678, 32'd0, 32'h1234_5678, 32'hFFFF_FFFF);

    // R9 deferred move-to in the middle and on the completion cycle
    cur_req = "R9";
    issue(3'd3, 32'd1000, 32'd10);
    repeat (5) @(negedge clk);
    issue_now(3'd4, 32'h0000_ABCD, 32'h0);
    issue_now(3'd4, 32'h0000_BEEF, 32'h0);
    wait_idle();
    read_both("R9", 32'h0000_BEEF, 32'd100);
    issue(3'd1, 32'd9, 32'd9);
    issue(3'd3, 32'd50, 32'd4);
    while (m_cnt > 1) @(negedge clk);
    issue_now(3'd5, 32'h5555_5555, 32'h0);
    wait_idle();
    read_both("R9", 32'd2, 32'h5555_5555);

    // R11 ignored issues
    cur_req = "R11";
    issue(3'd3, 32'd50, 32'd5);
    issue_now(3'd1, 32'd3, 32'd3);
    issue_now(3'd2, 32'd9, 32'd0);
    wait_idle();
    read_both("R11", 32'd0, 32'd10);
    issue(3'd6, 32'hDEAD_0001, 32'h1);
    issue(3'd7, 32'hDEAD_0002, 32'h2);
    read_both("R11", 32'd0, 32'd10);

    // mixed traffic, compared against the model every cycle
    cur_req = "R10";
    for (int k = 0; k < 300; k++) begin
      logic [2:0]  o;
      logic [31:0] a, b;
      o = 3'($urandom);
      a = $urandom;
      b = ($urandom % 8 == 0) ? 32'd0 : (($urandom % 2) ? $urandom : ($urandom % 64));
      issue(o, a, b);
      if ($urandom % 3 == 0) begin
        repeat ($urandom % 20) begin
          @(negedge clk);
          if ($urandom % 4 == 0) issue_now(3'($urandom), $urandom, $urandom);
        end
      end
      wait_idle();
    end

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule